// File: doc/BRIEF.md
# Phase Accumulator Waveform Core

This block is a numerically controlled oscillator. On every clock it adds a 28-bit tuning word to a phase accumulator. The tuning word comes from one of two frequency inputs. It then adds one of two 12-bit phase offsets to the accumulated phase. The summed phase is turned into a 10-bit offset-binary amplitude, either through a sine table or as a triangle ramp.

A separate single-bit output can carry the sample MSB directly, or a copy of it toggled at half rate. This bit serves as a coarse clock. The frequency and phase words and the control bits come from an external register file. The block produces only the digital sample and the bit; it contains no converter.

A clear control returns the core to phase zero with a midscale sample. A hold control freezes the core in place.

Top module: `nco_wave_core`

## Requirements
- R1: Each clock edge where clr_i=0 and hold_i=0 adds the selected frequency word to the 28-bit accumulator, modulo 2^28. fsel_i=0 selects freq0_i and fsel_i=1 selects freq1_i.
- R2: The phase sum is (acc + (phase << 16)) mod 2^28. The phase word is phase0_i when psel_i=0 and phase1_i when psel_i=1.
- R3: On the edge after clr_i=1, or while rst_ni=0, the accumulator is 0, sample_o is 512 and the half-rate bit is 0. clr_i has priority over hold_i.
- R4: On an edge with clr_i=0 and hold_i=1, the accumulator, sample_o and the half-rate bit all keep their values.
- R5: sample_o is registered. It is computed from the phase sum of the accumulator value present before the same edge.
- R6: Sine shaping takes p, the top 12 bits of the phase sum. Let k = p[9:0], or 1023-p[9:0] when p[10]=1, and m = round(511*sin(pi*(k+0.5)/2048)). The sample is 512+m when p[11]=0 and 511-m when p[11]=1.
- R7: Triangle shaping applies when tri_i=1 and bit_en_i=0. It takes t, the top 11 bits of the phase sum; the sample is t[9:0], or ~t[9:0] when t[10]=1.
- R8: bit_o is 0 when bit_en_i=0. It equals sample_o[9] when bit_en_i=1 and msb_direct_i=1.
- R9: When bit_en_i=1 and msb_direct_i=0, bit_o is the half-rate bit. That bit toggles on every edge, outside clear and hold, at which the new sample MSB is 1 and the previous sample MSB was 0.
- R10: When bit_en_i=1, sine shaping is used regardless of tri_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freq0_i | input | 28 | Frequency word 0 |
| freq1_i | input | 28 | Frequency word 1 |
| phase0_i | input | 12 | Phase offset 0 |
| phase1_i | input | 12 | Phase offset 1 |
| fsel_i | input | 1 | Frequency word select |
| psel_i | input | 1 | Phase offset select |
| clr_i | input | 1 | Synchronous clear to phase zero, midscale output |
| hold_i | input | 1 | Freeze accumulation and outputs |
| tri_i | input | 1 | Triangle shaping select |
| bit_en_i | input | 1 | Enable the single-bit output |
| msb_direct_i | input | 1 | 1: sample MSB on bit_o, 0: half-rate copy |
| sample_o | output | 10 | Offset-binary amplitude sample |
| bit_o | output | 1 | Square output bit |

## Verification
A wrong accumulator value shows up as a shifted sample on the very next edge. The error never heals, because every later sample inherits the phase error. A wrong frequency or phase select therefore gives a sample mismatch within one cycle of the switch.

A half-rate bit that toggles at the wrong MSB edge stays inverted until the next correct toggle. Comparing every cycle against the reference catches it at the first wrong edge. Hold and clear errors show within one cycle as a changed or non-midscale sample.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W = 28;
  localparam int unsigned PH_W  = 12;
  localparam int unsigned OUT_W = 10;
  localparam real         PI_R  = 3.141592653589793;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned ACC_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             fsel_i,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;

  assign step  = fsel_i ? freq1_i : freq0_i;
  assign acc_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (!hold_i) acc_q <= acc_q + step;
  end
endmodule

// File: rtl/nco_shaper.sv
module nco_shaper #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned PH_W  = 12,
  parameter int unsigned OUT_W = 10
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [PH_W-1:0]  phase0_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic             psel_i,
  input  logic             tri_i,
  input  logic             bit_en_i,
  output logic [OUT_W-1:0] sample_o
);
  localparam int unsigned QA_W  = PH_W - 2;
  localparam int unsigned QN    = 1 << QA_W;
  localparam int unsigned MAG_W = OUT_W - 1;
  localparam int unsigned MID   = 1 << MAG_W;
  localparam real         AMP   = real'(MID - 1);
  localparam real         STEPS = real'(2 * QN);

  logic [MAG_W-1:0] rom_q [QN];

  // quarter-wave magnitude table, computed at start
  initial begin
    for (int i = 0; i < int'(QN); i++) begin
      rom_q[i] = MAG_W'($rtoi(AMP * $sin(nco_pkg::PI_R * (real'(i) + 0.5) / STEPS) + 0.5));
    end
  end

  logic [PH_W-1:0]  ph_off;
  logic [ACC_W-1:0] ph_sum;
  logic [PH_W-1:0]  p_top;
  logic [QA_W-1:0]  q_idx;
  logic [OUT_W-1:0] mag;
  logic [OUT_W-1:0] sine_v;
  logic [OUT_W:0]   t_top;
  logic [OUT_W-1:0] tri_v;

  assign ph_off = psel_i ? phase1_i : phase0_i;
  assign ph_sum = acc_i + {ph_off, {(ACC_W-PH_W){1'b0}}};
  assign p_top  = ph_sum[ACC_W-1 -: PH_W];
  assign q_idx  = p_top[PH_W-2] ? ~p_top[QA_W-1:0] : p_top[QA_W-1:0];
  assign mag    = {1'b0, rom_q[q_idx]};
  assign sine_v = p_top[PH_W-1] ? (OUT_W'(MID - 1) - mag) : (OUT_W'(MID) + mag);
  assign t_top  = ph_sum[ACC_W-1 -: OUT_W+1];
  assign tri_v  = t_top[OUT_W] ? ~t_top[OUT_W-1:0] : t_top[OUT_W-1:0];

  // triangle is disallowed with the bit output; fall back to sine
  assign sample_o = (tri_i && !bit_en_i) ? tri_v : sine_v;
endmodule

// File: rtl/nco_wave_core.sv
module nco_wave_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_BITS = ACC_W,
  parameter int unsigned PH_BITS  = PH_W,
  parameter int unsigned OUT_BITS = OUT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ACC_BITS-1:0] freq0_i,
  input  logic [ACC_BITS-1:0] freq1_i,
  input  logic [PH_BITS-1:0]  phase0_i,
  input  logic [PH_BITS-1:0]  phase1_i,
  input  logic                fsel_i,
  input  logic                psel_i,
  input  logic                clr_i,
  input  logic                hold_i,
  input  logic                tri_i,
  input  logic                bit_en_i,
  input  logic                msb_direct_i,
  output logic [OUT_BITS-1:0] sample_o,
  output logic                bit_o
);
  localparam logic [OUT_BITS-1:0] MIDSCALE = OUT_BITS'(1 << (OUT_BITS - 1));

  logic [ACC_BITS-1:0] acc_q;
  logic [OUT_BITS-1:0] sample_d;
  logic [OUT_BITS-1:0] sample_q;
  logic                div_q;

  nco_accum #(.ACC_W(ACC_BITS)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .hold_i  (hold_i),
    .fsel_i  (fsel_i),
    .freq0_i (freq0_i),
    .freq1_i (freq1_i),
    .acc_o   (acc_q)
  );

  nco_shaper #(.ACC_W(ACC_BITS), .PH_W(PH_BITS), .OUT_W(OUT_BITS)) u_shaper (
    .acc_i    (acc_q),
    .phase0_i (phase0_i),
    .phase1_i (phase1_i),
    .psel_i   (psel_i),
    .tri_i    (tri_i),
    .bit_en_i (bit_en_i),
    .sample_o (sample_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= MIDSCALE;
      div_q    <= 1'b0;
    end else if (clr_i) begin
      sample_q <= MIDSCALE;
      div_q    <= 1'b0;
    end else if (!hold_i) begin
      sample_q <= sample_d;
      if (!sample_q[OUT_BITS-1] && sample_d[OUT_BITS-1]) div_q <= ~div_q;
    end
  end

  assign sample_o = sample_q;
  assign bit_o    = bit_en_i & (msb_direct_i ? sample_q[OUT_BITS-1] : div_q);
endmodule

// File: rtl/nco_wave_core_chk.sv
module nco_wave_core_chk #(
  parameter int unsigned ACC_BITS = 28,
  parameter int unsigned OUT_BITS = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                hold_i,
  input logic                fsel_i,
  input logic [ACC_BITS-1:0] freq0_i,
  input logic [ACC_BITS-1:0] freq1_i,
  input logic [ACC_BITS-1:0] acc_q,
  input logic                div_q,
  input logic [OUT_BITS-1:0] sample_o
);
  localparam logic [OUT_BITS-1:0] MIDSCALE = OUT_BITS'(1 << (OUT_BITS - 1));

  a_r1_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hold_i) |=> acc_q == ACC_BITS'($past(acc_q) + $past(fsel_i ? freq1_i : freq0_i)));

  a_r3_clear_midscale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sample_o == MIDSCALE) && (acc_q == '0) && !div_q);

  a_r4_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && hold_i) |=> $stable(sample_o) && $stable(acc_q) && $stable(div_q));

  a_r9_div_on_msb_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && (div_q != $past(div_q))) |-> $rose(sample_o[OUT_BITS-1]));
endmodule

bind nco_wave_core nco_wave_core_chk #(.ACC_BITS(ACC_BITS), .OUT_BITS(OUT_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .hold_i   (hold_i),
  .fsel_i   (fsel_i),
  .freq0_i  (freq0_i),
  .freq1_i  (freq1_i),
  .acc_q    (acc_q),
  .div_q    (div_q),
  .sample_o (sample_o)
);

// File: tb/nco_wave_core_tb_top.sv
`timescale 1ns/1ps
module nco_wave_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] freq0_i = '0, freq1_i = '0;
  logic [11:0] phase0_i = '0, phase1_i = '0;
  logic        fsel_i = 0, psel_i = 0, clr_i = 0, hold_i = 0;
  logic        tri_i = 0, bit_en_i = 0, msb_direct_i = 0;
  logic [9:0]  sample_o;
  logic        bit_o;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_tag = "R3";
  bit    run_cmp = 0;

  longint m_acc = 0;
  int     m_samp = 512;
  int     m_div = 0;

  always #2.5 clk_i = ~clk_i;

  nco_wave_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .freq0_i(freq0_i), .freq1_i(freq1_i),
    .phase0_i(phase0_i), .phase1_i(phase1_i), .fsel_i(fsel_i), .psel_i(psel_i),
    .clr_i(clr_i), .hold_i(hold_i), .tri_i(tri_i), .bit_en_i(bit_en_i),
    .msb_direct_i(msb_direct_i), .sample_o(sample_o), .bit_o(bit_o)
  );

  function automatic int ref_sine(int p);
    int k = p & 1023;
    int m;
    if (((p >> 10) & 1) == 1) k = 1023 - k;
    m = $rtoi(511.0 * $sin(3.141592653589793 * (real'(k) + 0.5) / 2048.0) + 0.5);
    return (((p >> 11) & 1) == 1) ? 511 - m : 512 + m;
  endfunction

  function automatic int ref_tri(int t);
    return (((t >> 10) & 1) == 1) ? 1023 - (t & 1023) : (t & 1023);
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk_i) begin
    longint ps;
    int     ns;
    if (!rst_ni || clr_i) begin
      m_acc = 0; m_samp = 512; m_div = 0;
    end else if (!hold_i) begin
      ps = (m_acc + (longint'(psel_i ? phase1_i : phase0_i) << 16)) % (64'd1 << 28);
      ns = (tri_i && !bit_en_i) ? ref_tri(int'(ps >> 17)) : ref_sine(int'(ps >> 16));
      if (m_samp < 512 && ns >= 512) m_div = 1 - m_div;
      m_samp = ns;
      m_acc = (m_acc + longint'(fsel_i ? freq1_i : freq0_i)) % (64'd1 << 28);
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    int eb;
    if (run_cmp) begin
      eb = !bit_en_i ? 0 : (msb_direct_i ? (m_samp >> 9) & 1 : m_div);
      check(cur_tag, int'(sample_o), m_samp, "sample_o");
      check(cur_tag, int'(bit_o), eb, "bit_o");
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R3", int'(sample_o), 512, "reset sample");
    check("R3", int'(bit_o), 0, "reset bit");
    rst_ni = 1'b1;
    run_cmp = 1;
    cycles(1);
    cur_tag = "R5"; freq0_i = 28'h0100000; freq1_i = 28'h0234567;
    phase0_i = 12'h000; phase1_i = 12'h400;
    cycles(600);
    cur_tag = "R1"; fsel_i = 1; cycles(400);
    cur_tag = "R2"; psel_i = 1; cycles(300);
    cur_tag = "R6"; psel_i = 0; fsel_i = 0; freq0_i = 28'h00C3501; cycles(600);
    cur_tag = "R7"; tri_i = 1; freq0_i = 28'h0100000; cycles(600);
    cur_tag = "R4"; hold_i = 1; cycles(50);
    hold_i = 0; cycles(10);
    cur_tag = "R3"; clr_i = 1; hold_i = 1; cycles(5);
    clr_i = 0; hold_i = 0; cycles(20);
    cur_tag = "R8"; tri_i = 0; bit_en_i = 1; msb_direct_i = 1; cycles(600);
    cur_tag = "R9"; msb_direct_i = 0; cycles(800);
    cur_tag = "R10"; tri_i = 1; cycles(300);
    cur_tag = "R4"; hold_i = 1; cycles(40);
    hold_i = 0; cycles(100);
    run_cmp = 0;
    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule